// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block is a hardware state machine that brings one secondary processor core out of power-down without software stepping through the sequence. A one-cycle request names the target core. The sequencer then works through a fixed chain of accesses on a simple register read/write port. The port reaches a global control word and one power-control word per core.

The sequencer first reads the global control word. If the target core is already out of reset, it reports success at once and writes nothing. Otherwise it reads the core's power-control word and keeps a running copy of it. It then applies eight read-modify-write steps:

- It raises logic power and waits for the acknowledge.
- It raises logic power-good and waits for the acknowledge.
- It drops the logic isolation clamp.
- It enables the memory arrays.
- It raises memory power and waits for the acknowledge.
- It raises memory power-good and waits for the acknowledge.
- It drops the memory clamp.
- It releases the core's reset in the global control word.

Each acknowledged step polls its own status field, and a programmable limit bounds the number of polls. A bus error, a poll timeout or an illegal core index ends the run with a coded error.

Top module: `core_pwrup_seq`

## Requirements
- R1: A request whose core index is 2 or more ends with `err_code` 3 and `err` high. No access is made on the register port.
- R2: The first access of a run is a read of address 0x30. If bit 13+core of the value read is 1, the run ends with `err_code` 0 after that single access, with no write.
- R3: The core's power-control word is at address 0x34 + 4×core. Only that address and 0x30 are ever accessed, so the other core's word is never touched.
- R4: A full run makes exactly eight writes. The first seven go to the core's power-control word and the last goes to 0x30. The cumulative effect of the first seven writes, in order, is: set bits [21:20], set bits [17:16], clear bit 15, clear bits [11:8], set bit 1, set bit 0, clear bit 2. Every write carries all bits from earlier steps (read-modify-write on a running copy).
- R5: After the writes of steps 1, 2, 5 and 6, the sequencer re-reads the power-control word until the status field reads all ones. The fields are [29:28], [25:24], bit 5 and bit 4 respectively. Steps 3, 4 and 7 are not followed by a read. With a status that appears after d unready reads, a full run takes 14+4d accesses.
- R6: The last write stores the saved global control value with bit 13+core set, and then the run ends with `err_code` 0.
- R7: An access answered with an error ends the run with `err_code` 1 in the cycle after the acknowledge. No further access is made.
- R8: Within one poll loop, at most `timeout_limit` reads are made; a limit of 0 acts as 1. If the status is still not ready on the last allowed read, the run ends with `err_code` 2.
- R9: `bus_req` stays high with stable address, write-enable and write data until `bus_ack` is seen. `bus_rdata` and `bus_err` are sampled in the acknowledge cycle.
- R10: `busy` is high from the cycle after an accepted request until the run ends. `done` is a single-cycle pulse at the end of the run. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, sampled when idle |
| req_core | input | CORE_W | Target core index |
| timeout_limit | input | CNT_W | Maximum reads per poll loop (0 treated as 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | High with `done` when the run failed |
| err_code | output | 2 | 0 ok, 1 bus error, 2 timeout, 3 bad core; held until the next run ends |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The main chain is run for both cores with status fields that answer after 0, 1 and 3 unready reads. Comparing each write against the cumulative bit image separates a wrong step order or a lost running copy. Comparing access counts separates missing or extra polls. Global control values that carry the other core's reset bit separate a correct per-core bit from a fixed one. A sweep that injects a bus error at every access position of a run shows that the abort is immediate and that the global word stays unchanged. Holding each of the four status fields stuck, with several limits, shows which poll loop times out and exactly where the limit boundary lies.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] GLOBAL_ADDR = 8'h30;
  localparam logic [AW-1:0] PWR_BASE    = 8'h34;
  localparam int            RST_BASE    = 13;

  localparam int            NUM_STEPS   = 8;
  localparam int            STEP_W      = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_BADCORE = 2'd3
  } cps_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GRD_I, S_GRD_W,
    S_PRD_I, S_PRD_W,
    S_WR_I,  S_WR_W,
    S_PL_I,  S_PL_W,
    S_FIN
  } cps_state_e;

  // bits a step sets in the running copy
  function automatic logic [DW-1:0] step_set(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return 32'h0030_0000;
      3'd1:    return 32'h0003_0000;
      3'd4:    return 32'h0000_0002;
      3'd5:    return 32'h0000_0001;
      default: return '0;
    endcase
  endfunction

  // bits a step clears in the running copy
  function automatic logic [DW-1:0] step_clr(input logic [STEP_W-1:0] s);
    case (s)
      3'd2:    return 32'h0000_8000;
      3'd3:    return 32'h0000_0F00;
      3'd6:    return 32'h0000_0004;
      default: return '0;
    endcase
  endfunction

  // status bits that must all read one before the step completes
  function automatic logic [DW-1:0] step_poll(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return 32'h3000_0000;
      3'd1:    return 32'h0300_0000;
      3'd4:    return 32'h0000_0020;
      3'd5:    return 32'h0000_0010;
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] pwr_addr(input logic [AW-1:0] core);
    return PWR_BASE + (core << 2);
  endfunction

  function automatic logic [DW-1:0] rst_bit(input logic [AW-1:0] core);
    return DW'(1) << (RST_BASE + int'(core));
  endfunction

endpackage

// File: rtl/cps_bus_port.sv
module cps_bus_port
  import cps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_done,
  output logic          xfer_err,
  output logic [DW-1:0] xfer_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (start) begin
      bus_req   <= 1'b1;
      bus_we    <= start_we;
      bus_addr  <= start_addr;
      bus_wdata <= start_wdata;
    end else if (bus_req && bus_ack) begin
      bus_req   <= 1'b0;
    end
  end

  assign xfer_done  = bus_req && bus_ack;
  assign xfer_err   = bus_err;
  assign xfer_rdata = bus_rdata;

endmodule

// File: rtl/cps_poll_timer.sv
module cps_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             miss,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] misses_q;

  // reads made so far in this loop, counting the one being answered
  function automatic logic [CNT_W:0] reads_made(input logic [CNT_W-1:0] m);
    return {1'b0, m} + 1'b1;
  endfunction

  assign expire = reads_made(misses_q) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               misses_q <= '0;
    else if (clear)           misses_q <= '0;
    else if (miss && !expire) misses_q <= misses_q + 1'b1;
  end

endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import cps_pkg::*;
#(
  parameter int CORE_W    = 2,
  parameter int NUM_CORES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  output logic              start,
  output logic              start_we,
  output logic [AW-1:0]     start_addr,
  output logic [DW-1:0]     start_wdata,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic [DW-1:0]     xfer_rdata,
  output logic              tmr_clear,
  output logic              tmr_miss,
  input  logic              tmr_expire,
  output logic              busy,
  output logic              done,
  output logic [1:0]        code,
  output logic [CORE_W-1:0] cur_core,
  output logic              ev_reject,
  output logic              ev_already,
  output logic              ev_abort,
  output logic              ev_timeout
);

  localparam logic [CORE_W:0] NC = (CORE_W+1)'(NUM_CORES);

  cps_state_e        state_q;
  logic [CORE_W-1:0] core_q;
  logic [DW-1:0]     gctl_q;
  logic [DW-1:0]     val_q;
  logic [STEP_W-1:0] step_q;
  cps_err_e          code_q;

  logic [AW-1:0] core_ext;
  logic [DW-1:0] poll_mask;
  logic          has_poll;
  logic          last_step;
  logic          hit;
  logic          bad_core;
  logic          on_bit;
  logic [DW-1:0] wr_word;

  assign core_ext  = AW'(core_q);
  assign poll_mask = step_poll(step_q);
  assign has_poll  = |poll_mask;
  assign last_step = step_q == LAST_STEP;
  assign hit       = (xfer_rdata & poll_mask) == poll_mask;
  assign bad_core  = {1'b0, req_core} >= NC;
  assign on_bit    = |(xfer_rdata & rst_bit(core_ext));
  assign wr_word   = last_step ? (gctl_q | rst_bit(core_ext))
                               : ((val_q | step_set(step_q)) & ~step_clr(step_q));

  // register-port drive
  always_comb begin
    start       = 1'b0;
    start_we    = 1'b0;
    start_addr  = pwr_addr(core_ext);
    start_wdata = '0;
    case (state_q)
      S_GRD_I: begin
        start      = 1'b1;
        start_addr = GLOBAL_ADDR;
      end
      S_PRD_I, S_PL_I: start = 1'b1;
      S_WR_I: begin
        start       = 1'b1;
        start_we    = 1'b1;
        start_addr  = last_step ? GLOBAL_ADDR : pwr_addr(core_ext);
        start_wdata = wr_word;
      end
      default: ;
    endcase
  end

  // named events
  assign ev_reject  = (state_q == S_IDLE) && req_valid && bad_core;
  assign ev_already = (state_q == S_GRD_W) && xfer_done && !xfer_err && on_bit;
  assign ev_abort   = xfer_done && xfer_err;
  assign ev_timeout = (state_q == S_PL_W) && xfer_done && !xfer_err && !hit && tmr_expire;
  assign tmr_clear  = (state_q == S_WR_W) && xfer_done;
  assign tmr_miss   = (state_q == S_PL_W) && xfer_done && !xfer_err && !hit;

  assign busy     = state_q != S_IDLE;
  assign done     = state_q == S_FIN;
  assign code     = code_q;
  assign cur_core = core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      core_q  <= '0;
      gctl_q  <= '0;
      val_q   <= '0;
      step_q  <= '0;
      code_q  <= ERR_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          core_q <= req_core;
          if (bad_core) begin
            code_q  <= ERR_BADCORE;
            state_q <= S_FIN;
          end else begin
            state_q <= S_GRD_I;
          end
        end
        S_GRD_I: state_q <= S_GRD_W;
        S_GRD_W: if (xfer_done) begin
          if (xfer_err) begin
            code_q  <= ERR_BUS;
            state_q <= S_FIN;
          end else if (on_bit) begin
            code_q  <= ERR_NONE;
            state_q <= S_FIN;
          end else begin
            gctl_q  <= xfer_rdata;
            state_q <= S_PRD_I;
          end
        end
        S_PRD_I: state_q <= S_PRD_W;
        S_PRD_W: if (xfer_done) begin
          if (xfer_err) begin
            code_q  <= ERR_BUS;
            state_q <= S_FIN;
          end else begin
            val_q   <= xfer_rdata;
            step_q  <= '0;
            state_q <= S_WR_I;
          end
        end
        S_WR_I: begin
          if (!last_step) val_q <= wr_word;
          state_q <= S_WR_W;
        end
        S_WR_W: if (xfer_done) begin
          if (xfer_err) begin
            code_q  <= ERR_BUS;
            state_q <= S_FIN;
          end else if (has_poll) begin
            state_q <= S_PL_I;
          end else if (last_step) begin
            code_q  <= ERR_NONE;
            state_q <= S_FIN;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_WR_I;
          end
        end
        S_PL_I: state_q <= S_PL_W;
        S_PL_W: if (xfer_done) begin
          if (xfer_err) begin
            code_q  <= ERR_BUS;
            state_q <= S_FIN;
          end else begin
            val_q <= xfer_rdata;
            if (hit) begin
              step_q  <= step_q + 1'b1;
              state_q <= S_WR_I;
            end else if (tmr_expire) begin
              code_q  <= ERR_TIMEOUT;
              state_q <= S_FIN;
            end else begin
              state_q <= S_PL_I;
            end
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import cps_pkg::*;
#(
  parameter int CORE_W    = 2,
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  input  logic [CNT_W-1:0]  timeout_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              bus_req,
  output logic              bus_we,
  output logic [7:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [31:0]       bus_rdata
);

  logic              start, start_we;
  logic [AW-1:0]     start_addr;
  logic [DW-1:0]     start_wdata;
  logic              xfer_done, xfer_err;
  logic [DW-1:0]     xfer_rdata;
  logic              tmr_clear, tmr_miss, tmr_expire;
  logic [CORE_W-1:0] cur_core;
  logic              ev_reject, ev_already, ev_abort, ev_timeout;

  cps_seq_fsm #(.CORE_W(CORE_W), .NUM_CORES(NUM_CORES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_core(req_core),
    .start(start), .start_we(start_we), .start_addr(start_addr), .start_wdata(start_wdata),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata),
    .tmr_clear(tmr_clear), .tmr_miss(tmr_miss), .tmr_expire(tmr_expire),
    .busy(busy), .done(done), .code(err_code), .cur_core(cur_core),
    .ev_reject(ev_reject), .ev_already(ev_already), .ev_abort(ev_abort), .ev_timeout(ev_timeout)
  );

  cps_bus_port u_port (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_we(start_we), .start_addr(start_addr), .start_wdata(start_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata)
  );

  cps_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(tmr_clear), .miss(tmr_miss), .limit(timeout_limit),
    .expire(tmr_expire)
  );

  assign err = done && (err_code != ERR_NONE);

endmodule

// File: rtl/core_pwrup_seq_checker.sv
module core_pwrup_seq_checker
  import cps_pkg::*;
#(
  parameter int CORE_W    = 2,
  parameter int NUM_CORES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CORE_W-1:0] req_core,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err_code,
  input logic              bus_req,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [CORE_W-1:0] cur_core,
  input logic              ev_already,
  input logic              ev_timeout
);

  localparam logic [CORE_W:0] NC = (CORE_W+1)'(NUM_CORES);

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && ({1'b0, req_core} >= NC)) |=> (done && err_code == 2'd3 && !bus_req));

  assert_already_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_already |=> (done && err_code == 2'd0 && !bus_req));

  assert_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr == GLOBAL_ADDR || bus_addr == pwr_addr(AW'(cur_core))));

  assert_bus_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> (done && err_code == 2'd1 && !bus_req));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (done && err_code == 2'd2));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind core_pwrup_seq core_pwrup_seq_checker #(.CORE_W(CORE_W), .NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
  .busy(busy), .done(done), .err_code(err_code),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack), .bus_err(bus_err), .cur_core(cur_core),
  .ev_already(ev_already), .ev_timeout(ev_timeout)
);

// File: tb/core_pwrup_seq_bench.sv
module core_pwrup_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CTL_MASK = 32'h0033_8F07;
  localparam logic [31:0] P_INIT   = 32'h0000_8F04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_core = '0;
  logic [15:0] timeout_limit = 16'd16;
  logic        busy, done, err;
  logic [1:0]  err_code;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwrup_seq u_core_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .timeout_limit(timeout_limit), .busy(busy), .done(done), .err(err), .err_code(err_code),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails  = 0;

  // register model state
  logic [31:0] m_gctl;
  logic [31:0] m_pwr [2];
  int          m_dly;
  int          m_dcnt [2][4];
  int          m_stuck;
  int          m_err_at;
  int          acc_cnt, wr_cnt, bad_addr, done_cnt;
  logic [7:0]  wr_addr [32];
  logic [31:0] wr_data [32];

  function automatic logic [31:0] rq_m(input int f);
    case (f)
      0: return 32'h0030_0000;
      1: return 32'h0003_0000;
      2: return 32'h0000_0002;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic logic [31:0] st_m(input int f);
    case (f)
      0: return 32'h3000_0000;
      1: return 32'h0300_0000;
      2: return 32'h0000_0020;
      default: return 32'h0000_0010;
    endcase
  endfunction

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (bus_ack) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
    end else if (bus_req) begin
      bus_ack = 1'b1;
      bus_rdata = '0;
      if (acc_cnt == m_err_at) begin
        bus_err = 1'b1;
      end else if (bus_addr == 8'h30) begin
        if (bus_we) begin
          m_gctl = bus_wdata;
          if (wr_cnt < 32) begin wr_addr[wr_cnt] = bus_addr; wr_data[wr_cnt] = bus_wdata; end
          wr_cnt++;
        end else bus_rdata = m_gctl;
      end else if (bus_addr == 8'h34 || bus_addr == 8'h38) begin
        int c;
        c = (bus_addr == 8'h38) ? 1 : 0;
        if (bus_we) begin
          for (int f = 0; f < 4; f++)
            if (((m_pwr[c] & rq_m(f)) != rq_m(f)) && ((bus_wdata & rq_m(f)) == rq_m(f)))
              m_dcnt[c][f] = m_dly;
          m_pwr[c] = bus_wdata & CTL_MASK;
          if (wr_cnt < 32) begin wr_addr[wr_cnt] = bus_addr; wr_data[wr_cnt] = bus_wdata; end
          wr_cnt++;
        end else begin
          bus_rdata = m_pwr[c];
          for (int f = 0; f < 4; f++)
            if ((m_pwr[c] & rq_m(f)) == rq_m(f)) begin
              if (m_dcnt[c][f] > 0) m_dcnt[c][f]--;
              else if (f != m_stuck) bus_rdata = bus_rdata | st_m(f);
            end
        end
      end else begin
        bad_addr++;
      end
      acc_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] g, input int dly, input int stuck, input int err_at,
                       input logic [15:0] lim);
    m_gctl = g; m_pwr[0] = P_INIT; m_pwr[1] = P_INIT;
    m_dly = dly; m_stuck = stuck; m_err_at = err_at;
    for (int c = 0; c < 2; c++) for (int f = 0; f < 4; f++) m_dcnt[c][f] = 0;
    acc_cnt = 0; wr_cnt = 0; bad_addr = 0; done_cnt = 0;
    timeout_limit = lim;
  endtask

  // issue one request and wait for the end-of-run pulse
  task automatic run(input logic [1:0] core, output logic [1:0] code, output bit ok);
    @(negedge clk);
    req_core = core; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    code = '0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1'b1; code = err_code; break; end
      @(negedge clk);
    end
    check(ok, "R10", "run ended", {31'd0, ok}, 32'd1);
    @(negedge clk);
    check(!done, "R10", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0]  code;
    bit          ok;
    logic [31:0] e [7];
    logic [31:0] g0;
    int          poll_step [4];
    poll_step = '{0, 1, 4, 5};
    setup(32'h0, 0, -1, -1, 16'd16);
    repeat (3) @(negedge clk);
    check(!busy && !done && !bus_req && err_code == 2'd0, "R10", "reset state",
          {28'd0, busy, done, bus_req, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // full runs, both cores, several acknowledge delays
    for (int c = 0; c < 2; c++) begin
      for (int di = 0; di < 3; di++) begin
        int d;
        d  = (di == 2) ? 3 : di;
        g0 = (c == 0) ? 32'h0000_4003 : 32'h0000_2300;
        setup(g0, d, -1, -1, 16'd8);
        run(2'(c), code, ok);
        check(code == 2'd0 && !err, "R6", "full run code", {30'd0, code}, 32'd0);
        check(acc_cnt == 14 + 4*d, "R5", "access count", acc_cnt, 14 + 4*d);
        check(wr_cnt == 8, "R4", "write count", wr_cnt, 8);
        check(bad_addr == 0, "R3", "stray address", bad_addr, 0);
        e[0] = P_INIT | 32'h0030_0000;
        e[1] = e[0] | 32'h0003_0000;
        e[2] = e[1] & ~32'h0000_8000;
        e[3] = e[2] & ~32'h0000_0F00;
        e[4] = e[3] | 32'h0000_0002;
        e[5] = e[4] | 32'h0000_0001;
        e[6] = e[5] & ~32'h0000_0004;
        for (int k = 0; k < 7; k++) begin
          check(wr_addr[k] == 8'(8'h34 + 4*c), "R3", "write address", {24'd0, wr_addr[k]}, 8'h34 + 4*c);
          check((wr_data[k] & CTL_MASK) == e[k], "R4", "write image", wr_data[k] & CTL_MASK, e[k]);
        end
        check(wr_addr[7] == 8'h30, "R6", "release address", {24'd0, wr_addr[7]}, 32'h30);
        check(wr_data[7] == (g0 | (32'd1 << (13 + c))), "R6", "release data",
              wr_data[7], g0 | (32'd1 << (13 + c)));
        check(m_pwr[1-c] == P_INIT, "R3", "other core untouched", m_pwr[1-c], P_INIT);
      end
    end

    // already-on shortcut
    for (int c = 0; c < 2; c++) begin
      setup(32'd1 << (13 + c), 0, -1, -1, 16'd8);
      run(2'(c), code, ok);
      check(code == 2'd0, "R2", "already on code", {30'd0, code}, 0);
      check(acc_cnt == 1 && wr_cnt == 0, "R2", "already on accesses", acc_cnt, 1);
    end

    // illegal core index
    for (int c = 2; c < 4; c++) begin
      setup(32'h0, 0, -1, -1, 16'd8);
      run(2'(c), code, ok);
      check(code == 2'd3, "R1", "bad core code", {30'd0, code}, 3);
      check(acc_cnt == 0, "R1", "bad core accesses", acc_cnt, 0);
    end

    // bus error at every position
    for (int ea = 0; ea < 14; ea++) begin
      setup(32'h0000_0100, 0, -1, ea, 16'd8);
      run(2'd0, code, ok);
      check(code == 2'd1, "R7", "bus error code", {30'd0, code}, 1);
      check(acc_cnt == ea + 1, "R7", "accesses after error", acc_cnt, ea + 1);
      check(m_gctl == 32'h0000_0100, "R7", "global word unchanged", m_gctl, 32'h100);
    end

    // stuck status per poll loop
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 3; li++) begin
        int lim, eff;
        lim = (li == 0) ? 0 : ((li == 1) ? 1 : 3);
        eff = (lim == 0) ? 1 : lim;
        setup(32'h0, 0, p, -1, 16'(lim));
        run(2'd1, code, ok);
        check(code == 2'd2, "R8", "timeout code", {30'd0, code}, 2);
        check(acc_cnt == 3 + poll_step[p] + p + eff, "R8", "timeout accesses",
              acc_cnt, 3 + poll_step[p] + p + eff);
      end
    end

    // limit boundary: 3 unready reads need a limit of 4
    setup(32'h0, 3, -1, -1, 16'd4);
    run(2'd1, code, ok);
    check(code == 2'd0, "R8", "limit just enough", {30'd0, code}, 0);
    setup(32'h0, 3, -1, -1, 16'd3);
    run(2'd1, code, ok);
    check(code == 2'd2 && acc_cnt == 6, "R8", "limit one short", acc_cnt, 6);

    // request while busy is ignored
    setup(32'h0, 3, -1, -1, 16'd8);
    @(negedge clk);
    req_core = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R10", "busy after request", {31'd0, busy}, 1);
    repeat (4) @(negedge clk);
    req_core = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(done_cnt == 1, "R10", "one run only", done_cnt, 1);
    check(m_pwr[1] == P_INIT && m_gctl == 32'h0000_2000, "R10", "second request ignored",
          m_gctl, 32'h0000_2000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule